// File: doc/BRIEF.md
# Event-Triggered Timebase Capture Unit

This block takes a snapshot of a free-running PWM timebase count. The snapshot is taken when a chosen hardware event asserts, or when software asks for one. There are five event inputs: sync, feed-forward, current-limit, fault 1 and fault 2. Each passes through a two-flop synchronizer. After that, a capture fires only on the rising edge of the input, so a level that stays high does not cause repeated captures. Software can request a capture at any time, whatever source is configured.

The block can also do trigger copy. When both the capture-point enable and the copy enable are set, each capture also writes half of the captured count into one of four trigger-compare registers. The register is picked by a 2-bit destination field. The comparators downstream use those registers to place events at the midpoint of the captured interval. Every capture sets a sticky done flag, and software clears that flag with a strobe.

Top module: `tbcap_unit`

## Requirements
- R1: After reset, the capture register, all four trigger registers and the done flag read 0. The configuration is also 0, which means software-only capture with trigger copy disabled.
- R2: The source field selects the hardware capture source: code 1 is sync (evt_in[0]), 2 is feed-forward (evt_in[1]), 3 is current-limit (evt_in[2]), 4 is fault 1 (evt_in[3]) and 5 is fault 2 (evt_in[4]). When the selected input rises, the count present at the third rising clock edge at which that input is seen high is captured.
- R3: An input that stays high causes only one capture. Edges on inputs that are not selected cause no capture.
- R4: Source codes 0, 6 and 7 never cause a hardware capture.
- R5: A cycle with cap_wr=1 and cap_wr_lsb=1 captures the count present at that clock edge, whatever the source code. With cap_wr_lsb=0 nothing is captured.
- R6: On a capture, if both pt_en and xfer_en are 1, the selected trigger register receives the captured count shifted right by one bit, on the same edge as the capture. Otherwise no trigger register changes.
- R7: The destination field value 0 selects trig_c, 1 selects trig_d, 2 selects trig_e and 3 selects trig_f. Trigger registers that are not selected keep their values.
- R8: A software request and a selected hardware edge in the same cycle make a single capture of that cycle's count.
- R9: cap_done is set by every capture and stays set until a cycle with done_clr=1. If a capture and done_clr fall in the same cycle, the flag ends up set.
- R10: A cycle with cfg_we=1 loads cfg_wdata into the configuration. The field layout is: bit 0 pt_en, bits 3:1 source, bit 4 xfer_en, bits 6:5 destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_count | input | CNT_W | Timebase count to capture |
| evt_in | input | 5 | Asynchronous event inputs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration write data |
| cap_wr | input | 1 | Capture register write strobe |
| cap_wr_lsb | input | 1 | Bit 0 of the capture register write data |
| done_clr | input | 1 | Clears the done flag |
| cap_val | output | CNT_W | Captured count |
| trig_c | output | CNT_W | Trigger register C |
| trig_d | output | CNT_W | Trigger register D |
| trig_e | output | CNT_W | Trigger register E |
| trig_f | output | CNT_W | Trigger register F |
| cap_done | output | 1 | Sticky capture-done flag |

## Verification
The hardest case to reach is a software request arriving in the very cycle the synchronized hardware edge is detected. That edge only exists two clocks after the input changes. To hit it, the stimulus raises the sync input and then asserts the software strobe exactly two clock periods later. It then checks that one consistent value lands in the capture register and in the chosen trigger register. A separate step holds an event high while the count keeps moving, which shows that no second capture follows the first.

// File: rtl/tbcap_pkg.sv
package tbcap_pkg;
    localparam int NUM_EVT  = 5;
    localparam int NUM_TRIG = 4;
    localparam int SRC_W    = 3;
    localparam int SEL_W    = $clog2(NUM_TRIG);

    // packed MSB first: bit 0 pt_en, [3:1] src, [4] xfer_en, [6:5] dst
    typedef struct packed {
        logic [SEL_W-1:0] dst;
        logic             xfer_en;
        logic [SRC_W-1:0] src;
        logic             pt_en;
    } cap_cfg_t;

    localparam int CFG_W = $bits(cap_cfg_t);
endpackage

// File: rtl/tbcap_sync.sv
module tbcap_sync #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_in,
    output logic [N-1:0] evt_rise
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = evt_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_rise = st_q.s2 & ~st_q.prev;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R3: a detected edge never repeats on the next cycle
        p_single_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
            evt_rise[i] |=> !evt_rise[i]);
    end
endmodule

// File: rtl/tbcap_cfg.sv
module tbcap_cfg
    import tbcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cap_cfg_t         cfg
);
    cap_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = cap_cfg_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    p_cfg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cfg_q == cap_cfg_t'($past(wdata)));
endmodule

// File: rtl/tbcap_core.sv
module tbcap_core
    import tbcap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [W-1:0]                    tb_count,
    input  logic [NUM_EVT-1:0]              evt_rise,
    input  cap_cfg_t                        cfg,
    input  logic                            sw_req,
    input  logic                            done_clr,
    output logic [W-1:0]                    cap_val,
    output logic [NUM_TRIG-1:0][W-1:0]      trig,
    output logic                            done
);
    typedef struct packed {
        logic [W-1:0]                 cap;
        logic [NUM_TRIG-1:0][W-1:0]   trig;
        logic                         done;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     hw_hit;
    logic     fire;
    logic     copy_on;

    always_comb begin
        hw_hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (cfg.src == SRC_W'(i + 1)) hw_hit = evt_rise[i];
        end
        fire    = hw_hit | sw_req;
        copy_on = cfg.pt_en & cfg.xfer_en;

        st_d = st_q;
        if (done_clr) st_d.done = 1'b0;
        if (fire) begin
            st_d.cap  = tb_count;
            st_d.done = 1'b1;
            for (int t = 0; t < NUM_TRIG; t++) begin
                if (copy_on && cfg.dst == SEL_W'(t)) st_d.trig[t] = tb_count >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_val = st_q.cap;
    assign trig    = st_q.trig;
    assign done    = st_q.done;

    p_sw_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> cap_val == $past(tb_count));
    p_reserved_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_req && (cfg.src == 3'd6 || cfg.src == 3'd7)) |=> $stable(cap_val));
    p_done_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> done);

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig_chk
        p_trig_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && copy_on && cfg.dst == SEL_W'(t)) |=> trig[t] == ($past(tb_count) >> 1));
        p_trig_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(fire && copy_on && cfg.dst == SEL_W'(t)) |=> $stable(trig[t]));
    end
endmodule

// File: rtl/tbcap_unit.sv
module tbcap_unit
    import tbcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     tb_count,
    input  logic [NUM_EVT-1:0]   evt_in,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 cap_wr,
    input  logic                 cap_wr_lsb,
    input  logic                 done_clr,
    output logic [CNT_W-1:0]     cap_val,
    output logic [CNT_W-1:0]     trig_c,
    output logic [CNT_W-1:0]     trig_d,
    output logic [CNT_W-1:0]     trig_e,
    output logic [CNT_W-1:0]     trig_f,
    output logic                 cap_done
);
    logic [NUM_EVT-1:0]            rise;
    cap_cfg_t                      cfg;
    logic [NUM_TRIG-1:0][CNT_W-1:0] trig;

    tbcap_sync #(.N(NUM_EVT)) u_sync (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_rise(rise)
    );

    tbcap_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
    );

    tbcap_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .evt_rise(rise),
        .cfg(cfg), .sw_req(cap_wr & cap_wr_lsb), .done_clr(done_clr),
        .cap_val(cap_val), .trig(trig), .done(cap_done)
    );

    assign trig_c = trig[0];
    assign trig_d = trig[1];
    assign trig_e = trig[2];
    assign trig_f = trig[3];
endmodule

// File: tb/tbcap_unit_tb.sv
`timescale 1ns/1ps
module tbcap_unit_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tb_count = '0;
    logic [4:0]   evt_in = '0;
    logic         cfg_we = 1'b0;
    logic [6:0]   cfg_wdata = '0;
    logic         cap_wr = 1'b0;
    logic         cap_wr_lsb = 1'b0;
    logic         done_clr = 1'b0;
    logic [W-1:0] cap_val, trig_c, trig_d, trig_e, trig_f;
    logic         cap_done;

    always #2 clk = ~clk;

    tbcap_unit #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .evt_in(evt_in),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cap_wr(cap_wr),
        .cap_wr_lsb(cap_wr_lsb), .done_clr(done_clr), .cap_val(cap_val),
        .trig_c(trig_c), .trig_d(trig_d), .trig_e(trig_e), .trig_f(trig_f),
        .cap_done(cap_done)
    );

    typedef struct {
        string        req;
        int           fld;
        logic [W-1:0] exp;
    } item_t;

    item_t        sb_q[$];
    int           total = 0;
    int           bad = 0;
    bit           finished = 0;
    logic [W-1:0] m_cap;
    logic [W-1:0] m_trig [4];

    function automatic logic [W-1:0] actual(int fld);
        case (fld)
            0: return cap_val;
            1: return trig_c;
            2: return trig_d;
            3: return trig_e;
            4: return trig_f;
            default: return {{(W-1){1'b0}}, cap_done};
        endcase
    endfunction

    // monitor: compares queued expectations while outputs are stable
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (actual(it.fld) !== it.exp) begin
                    bad++;
                    $display("FAIL %s field=%0d actual=%h expected=%h",
                             it.req, it.fld, actual(it.fld), it.exp);
                end
            end
        end
    end

    task automatic push(string req, int fld, logic [W-1:0] exp);
        item_t it;
        it.req = req; it.fld = fld; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic push_all(string req, logic done_exp);
        push(req, 0, m_cap);
        for (int t = 0; t < 4; t++) push(req, t + 1, m_trig[t]);
        push(req, 5, {{(W-1){1'b0}}, done_exp});
    endtask

    // R10 layout: [0] pt_en, [3:1] src, [4] xfer_en, [6:5] dst
    task automatic cfg_write(logic pt, logic [2:0] src, logic xf, logic [1:0] dst);
        cfg_wdata = {dst, xf, src, pt};
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sw_cap(logic [W-1:0] cnt, logic lsb);
        tb_count = cnt;
        cap_wr = 1'b1; cap_wr_lsb = lsb;
        @(negedge clk);
        cap_wr = 1'b0; cap_wr_lsb = 1'b0;
    endtask

    task automatic clr_done();
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    task automatic hw_pulse(int idx, logic [W-1:0] cnt);
        tb_count = cnt;
        evt_in[idx] = 1'b1;
        repeat (3) @(negedge clk);
        evt_in[idx] = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_cap = '0;
        for (int t = 0; t < 4; t++) m_trig[t] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_all("R1", 1'b0);
        @(negedge clk);

        // R5: software capture with source 0, copy off -> trig untouched (R6)
        sw_cap(16'h1234, 1'b1); m_cap = 16'h1234;
        push_all("R5", 1'b1);
        @(negedge clk);
        // R9: clear
        clr_done();
        push("R9", 5, 16'h0);
        @(negedge clk);
        // R5: lsb=0 makes no capture
        sw_cap(16'h5555, 1'b0);
        push("R5", 0, m_cap);
        push("R5", 5, 16'h0);
        @(negedge clk);

        // R2 / R3: every source code, plus edges on a non-selected input
        for (int i = 0; i < 5; i++) begin
            logic [W-1:0] cnt;
            cfg_write(1'b0, 3'(i + 1), 1'b0, 2'd0);
            hw_pulse((i + 1) % 5, 16'h0F00 + 16'(i));
            settle();
            push("R3", 0, m_cap);
            cnt = 16'h0100 * 16'(i + 1) + 16'h0007;
            hw_pulse(i, cnt); m_cap = cnt;
            push("R2", 0, m_cap);
            settle();
        end

        // R3: level held high captures once
        cfg_write(1'b0, 3'd1, 1'b0, 2'd0);
        tb_count = 16'h0A0A;
        evt_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        m_cap = 16'h0A0A;
        push("R3", 0, m_cap);
        tb_count = 16'h0B0B;
        repeat (6) @(negedge clk);
        push("R3", 0, m_cap);
        evt_in[0] = 1'b0;
        settle();

        // R4: reserved codes ignore all events, software still works (R5)
        for (int c = 6; c < 8; c++) begin
            cfg_write(1'b0, 3'(c), 1'b0, 2'd0);
            tb_count = 16'hDEAD;
            evt_in = 5'h1F;
            repeat (4) @(negedge clk);
            evt_in = 5'h00;
            settle();
            push("R4", 0, m_cap);
        end
        sw_cap(16'h4321, 1'b1); m_cap = 16'h4321;
        push("R5", 0, m_cap);
        @(negedge clk);

        // R6 / R7: each destination gets half, others keep values
        for (int d = 0; d < 4; d++) begin
            logic [W-1:0] cnt;
            cfg_write(1'b1, 3'd0, 1'b1, 2'(d));
            cnt = 16'h2001 + 16'h0111 * 16'(d);
            sw_cap(cnt, 1'b1);
            m_cap = cnt; m_trig[d] = cnt >> 1;
            push_all("R7", 1'b1);
            @(negedge clk);
        end
        // R6: gating by pt_en and by xfer_en
        cfg_write(1'b0, 3'd0, 1'b1, 2'd1);
        sw_cap(16'hFFFF, 1'b1); m_cap = 16'hFFFF;
        push_all("R6", 1'b1);
        @(negedge clk);
        cfg_write(1'b1, 3'd0, 1'b0, 2'd1);
        sw_cap(16'hEEEE, 1'b1); m_cap = 16'hEEEE;
        push_all("R6", 1'b1);
        @(negedge clk);
        // R6: hardware capture path (fault 1) into trig_e
        cfg_write(1'b1, 3'd4, 1'b1, 2'd2);
        hw_pulse(3, 16'h0C35); m_cap = 16'h0C35; m_trig[2] = 16'h061A;
        push_all("R6", 1'b1);
        settle();

        // R8: software request coincides with sync edge detection
        cfg_write(1'b1, 3'd1, 1'b1, 2'd0);
        clr_done();
        tb_count = 16'h7FFF;
        evt_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        cap_wr = 1'b1; cap_wr_lsb = 1'b1;
        @(negedge clk);
        cap_wr = 1'b0; cap_wr_lsb = 1'b0;
        m_cap = 16'h7FFF; m_trig[0] = 16'h3FFF;
        push_all("R8", 1'b1);
        evt_in[0] = 1'b0;
        settle();
        push("R8", 0, m_cap);
        push("R8", 1, m_trig[0]);

        // R9: capture and clear in the same cycle -> set wins
        cfg_write(1'b0, 3'd0, 1'b0, 2'd0);
        clr_done();
        push("R9", 5, 16'h0);
        @(negedge clk);
        done_clr = 1'b1;
        sw_cap(16'h0042, 1'b1); m_cap = 16'h0042;
        done_clr = 1'b0;
        push("R9", 5, 16'h1);
        push("R9", 0, m_cap);
        @(negedge clk);
        clr_done();
        push("R9", 5, 16'h0);
        repeat (2) @(negedge clk);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule